// File: doc/BRIEF.md
# Steerable Two-Class Interrupt Controller

This block gathers twenty interrupt request lines, four from outside the chip and sixteen from on-chip peripherals, into one pending word. Each source is captured on a rising edge of its line. The external lines first pass through a two-flop synchroniser. A per-source enable mask decides which pending bits may interrupt the processor. A per-source route bit sends each source either to the normal interrupt output `irq_o` or to the fast interrupt output `fiq_o`. A write-one injection register lets software raise any internal source without the peripheral, which is useful for tests.

Software reaches the block through a plain single-cycle register bus with a byte offset. A write takes effect at the clock edge where `bus_wr_i` is high. Reads are combinational from `bus_addr_i` and need no strobe. The bus moves only control and status words, so it has no valid/ready handshake and never applies back-pressure. Through it, software reads the raw and masked pending words and the raw and masked views for each output class. It writes the enable, route, injection and clear registers. Priority encoding and vectoring are left to the software handler.

Top module: `intc_steer`

## Requirements
- R1: Pending bit k (k = 0..3) belongs to `ext_req_i[k]`, and pending bit 4+k (k = 0..15) belongs to `int_req_i[k]`. Bits 31:20 of every read are zero.
- R2: A rise on `int_req_i` sets its pending bit at the first clock edge after it. A rise on `ext_req_i` sets its bit at the third edge, after two synchroniser stages. A line that is held high does not set its bit again once the bit is cleared.
- R3: Offset 0x14 reads the pending word ANDed with the enable mask. Offset 0x04 holds the read/write enable mask, and offset 0x00 reads the raw pending word.
- R4: Offset 0x18 is the injection register. While one of its bits 19:4 is 1, the matching pending bit is set every cycle. Bits 3:0 ignore writes and read 0, so they cannot raise an external source.
- R5: After reset, the pending word, enable mask, route register and injection register are all zero, and `irq_o` and `fiq_o` are low.
- R6: Offset 0x08 holds the route register, where 1 means fast. Offset 0x20 reads pending AND NOT route. Offset 0x24 reads pending AND route.
- R7: Offset 0x28 reads the 0x20 view ANDed with the enable mask. Offset 0x2C reads the 0x24 view ANDed with the enable mask.
- R8: Writing 1 to a bit at offset 0x0C clears that pending bit. A new request in the same cycle wins over the clear. Offset 0x0C reads 0.
- R9: One clock edge after any bit of the 0x28 view is set, `irq_o` is high. One clock edge after any bit of the 0x2C view is set, `fiq_o` is high. Each output is low one edge after its view is empty.
- R10: Writes to bits 31:20 of the enable, route and injection registers are ignored. Offsets that are not listed read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req_i | input | 4 | Asynchronous external request lines |
| int_req_i | input | 16 | Synchronous peripheral request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Normal-class interrupt, registered |
| fiq_o | output | 1 | Fast-class interrupt, registered |

## Verification
The hardest case to reach is a new rising edge on a source in the very cycle that software clears that same bit. To produce it, the bench drives a peripheral line up and writes the clear register at the same falling edge, so both reach one rising edge together. The external path has the same difficulty with its cycle-exact latency. For it, the bench raises a line and reads the pending word after one, two and three edges. Random enable, route and request patterns then cover the six views and both outputs.

// File: rtl/intc_steer_pkg.sv
package intc_steer_pkg;
  localparam int unsigned N_EXT_D = 4;
  localparam int unsigned N_INT_D = 16;
  localparam int unsigned DW_D    = 32;
  localparam int unsigned AW_D    = 6;

  // word index (byte offset / 4) of each register
  localparam logic [3:0] WI_PEND  = 4'h0;
  localparam logic [3:0] WI_EN    = 4'h1;
  localparam logic [3:0] WI_ROUTE = 4'h2;
  localparam logic [3:0] WI_CLR   = 4'h3;
  localparam logic [3:0] WI_MPEND = 4'h5;
  localparam logic [3:0] WI_INJ   = 4'h6;
  localparam logic [3:0] WI_RNRM  = 4'h8;
  localparam logic [3:0] WI_RFST  = 4'h9;
  localparam logic [3:0] WI_MNRM  = 4'hA;
  localparam logic [3:0] WI_MFST  = 4'hB;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned N_INT = 16,
  parameter int unsigned SYNC  = 2,
  localparam int unsigned NSRC = N_EXT + N_INT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_i,
  input  logic [N_INT-1:0] int_i,
  output logic [NSRC-1:0]  rise_o
);
  logic [SYNC-1:0][N_EXT-1:0] stage_q;
  logic [N_EXT-1:0]           ext_prev_q;
  logic [N_INT-1:0]           int_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= ext_i;
  end

  for (genvar s = 1; s < SYNC; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_prev_q <= '0;
      int_prev_q <= '0;
    end else begin
      ext_prev_q <= stage_q[SYNC-1];
      int_prev_q <= int_i;
    end
  end

  assign rise_o = {int_i & ~int_prev_q, stage_q[SYNC-1] & ~ext_prev_q};
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned NSRC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  // a set in the same cycle overrides a clear
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_steer_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned N_INT = 16,
  parameter int unsigned AW    = 6,
  localparam int unsigned NSRC = N_EXT + N_INT,
  localparam int unsigned WIW  = AW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [WIW-1:0]  widx_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] route_o,
  output logic [NSRC-1:0] inj_o,
  output logic [NSRC-1:0] clr_o
);
  localparam logic [NSRC-1:0] INJ_MASK = {{N_INT{1'b1}}, {N_EXT{1'b0}}};

  logic [NSRC-1:0] en_q, route_q, inj_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      inj_q   <= '0;
    end else if (wr_i) begin
      if (widx_i == WIW'(WI_EN))    en_q    <= wdata_i;
      if (widx_i == WIW'(WI_ROUTE)) route_q <= wdata_i;
      if (widx_i == WIW'(WI_INJ))   inj_q   <= wdata_i & INJ_MASK;
    end
  end

  assign clr_o   = (wr_i && widx_i == WIW'(WI_CLR)) ? wdata_i : '0;
  assign en_o    = en_q;
  assign route_o = route_q;
  assign inj_o   = inj_q;
endmodule

// File: rtl/intc_steer.sv
module intc_steer
  import intc_steer_pkg::*;
#(
  parameter int unsigned N_EXT = N_EXT_D,
  parameter int unsigned N_INT = N_INT_D,
  parameter int unsigned DW    = DW_D,
  parameter int unsigned AW    = AW_D,
  localparam int unsigned NSRC = N_EXT + N_INT,
  localparam int unsigned WIW  = AW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_req_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic             bus_wr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [NSRC-1:0] rise_vec, set_vec, clr_vec, pend_q;
  logic [NSRC-1:0] en_q, sel_q, test_q;
  logic [NSRC-1:0] v_mpend, v_rnrm, v_rfst, v_mnrm, v_mfst, rd_word;
  logic [WIW-1:0]  widx;
  logic            irq_q, fiq_q;
  logic            unused_bits;

  assign widx        = bus_addr_i[AW-1:2];
  assign unused_bits = ^{bus_wdata_i[DW-1:NSRC], bus_addr_i[1:0]};

  intc_capture #(.N_EXT(N_EXT), .N_INT(N_INT), .SYNC(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_req_i), .int_i(int_req_i),
    .rise_o(rise_vec)
  );

  intc_cfg #(.N_EXT(N_EXT), .N_INT(N_INT), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .widx_i(widx),
    .wdata_i(bus_wdata_i[NSRC-1:0]), .en_o(en_q), .route_o(sel_q),
    .inj_o(test_q), .clr_o(clr_vec)
  );

  assign set_vec = rise_vec | test_q;

  intc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
    .pend_o(pend_q)
  );

  assign v_mpend = pend_q & en_q;
  assign v_rnrm  = pend_q & ~sel_q;
  assign v_rfst  = pend_q & sel_q;
  assign v_mnrm  = v_rnrm & en_q;
  assign v_mfst  = v_rfst & en_q;

  always_comb begin
    rd_word = '0;
    if (widx == WIW'(WI_PEND))  rd_word = pend_q;
    if (widx == WIW'(WI_EN))    rd_word = en_q;
    if (widx == WIW'(WI_ROUTE)) rd_word = sel_q;
    if (widx == WIW'(WI_MPEND)) rd_word = v_mpend;
    if (widx == WIW'(WI_INJ))   rd_word = test_q;
    if (widx == WIW'(WI_RNRM))  rd_word = v_rnrm;
    if (widx == WIW'(WI_RFST))  rd_word = v_rfst;
    if (widx == WIW'(WI_MNRM))  rd_word = v_mnrm;
    if (widx == WIW'(WI_MFST))  rd_word = v_mfst;
  end

  assign bus_rdata_o = {{(DW-NSRC){1'b0}}, rd_word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |v_mnrm;
      fiq_q <= |v_mfst;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
endmodule

// File: rtl/intc_steer_chk.sv
module intc_steer_chk #(
  parameter int unsigned NSRC  = 20,
  parameter int unsigned N_EXT = 4,
  parameter int unsigned DW    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] set_vec,
  input logic [NSRC-1:0] clr_vec,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] sel,
  input logic [NSRC-1:0] test,
  input logic            irq,
  input logic            fiq,
  input logic [DW-1:0]   rdata
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NSRC] == '0);

  p_new_bit_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0));

  p_inj_ext_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test[N_EXT-1:0] == '0);

  p_reset_state_r5: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend == '0 && en == '0 && sel == '0 && test == '0 && !irq && !fiq));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(pend & en & ~sel)));

  p_fiq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> $past(|(pend & en & sel)));
endmodule

bind intc_steer intc_steer_chk #(.NSRC(NSRC), .N_EXT(N_EXT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_q), .set_vec(set_vec),
  .clr_vec(clr_vec), .en(en_q), .sel(sel_q), .test(test_q),
  .irq(irq_o), .fiq(fiq_o), .rdata(bus_rdata_o)
);

// File: tb/intc_steer_tb.sv
module intc_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_req_i = '0;
  logic [15:0] int_req_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  intc_steer u_dut (
    .clk(clk), .rst_n(rst_n), .ext_req_i(ext_req_i), .int_req_i(int_req_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam logic [31:0] ALL = 32'h000F_FFFF;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] f_rnrm(input logic [31:0] p, input logic [31:0] s);
    return p & ~s & ALL;
  endfunction
  function automatic logic [31:0] f_rfst(input logic [31:0] p, input logic [31:0] s);
    return p & s & ALL;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, p, e, s;
    void'($urandom(32'h1c5eed));
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset state
    for (int a = 0; a < 16; a++) begin
      peek(6'(a * 4), d);
      check("R5 reset read", d, 32'h0);
    end
    check("R5 irq_o after reset", {31'b0, irq_o}, 32'h0);
    check("R5 fiq_o after reset", {31'b0, fiq_o}, 32'h0);

    // R10 reserved write bits and unmapped offsets
    wr(6'h04, 32'hFFFF_FFFF);
    peek(6'h04, d); check("R10 enable reserved bits", d, ALL);
    wr(6'h08, 32'hFFF0_0000);
    peek(6'h08, d); check("R10 route reserved bits", d, 32'h0);
    peek(6'h0C, d); check("R8 clear reads zero", d, 32'h0);
    peek(6'h10, d); check("R10 unmapped 0x10", d, 32'h0);
    peek(6'h1C, d); check("R10 unmapped 0x1C", d, 32'h0);
    peek(6'h30, d); check("R10 unmapped 0x30", d, 32'h0);

    // R2 internal latency and R9 output one edge later
    wr(6'h04, 32'h20);
    @(negedge clk);
    int_req_i[1] = 1'b1;
    peek(6'h00, d); check("R2 internal before edge", d, 32'h0);
    @(negedge clk);
    peek(6'h00, d); check("R2 internal after one edge, R1 bit 5", d, 32'h20);
    check("R9 irq_o not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 irq_o one edge later", {31'b0, irq_o}, 32'h1);
    check("R9 fiq_o stays low", {31'b0, fiq_o}, 32'h0);

    // R2 external latency through synchroniser
    ext_req_i[2] = 1'b1;
    @(negedge clk); peek(6'h00, d); check("R2 external after 1 edge", d, 32'h20);
    @(negedge clk); peek(6'h00, d); check("R2 external after 2 edges", d, 32'h20);
    @(negedge clk); peek(6'h00, d); check("R2 external after 3 edges, R1 bit 2", d, 32'h24);

    // R2 held level does not re-set after clear
    wr(6'h0C, 32'h24);
    cycles(4);
    peek(6'h00, d); check("R2 held level no re-set", d, 32'h0);
    check("R9 irq_o drops", {31'b0, irq_o}, 32'h0);
    ext_req_i = '0; int_req_i = '0;
    cycles(5);

    // R8 set wins over clear in same cycle
    @(negedge clk);
    int_req_i[0] = 1'b1;
    bus_wr_i = 1'b1; bus_addr_i = 6'h0C; bus_wdata_i = 32'h10;
    @(negedge clk);
    bus_wr_i = 1'b0;
    peek(6'h00, d); check("R8 set beats clear", d, 32'h10);
    wr(6'h0C, 32'h10);
    peek(6'h00, d); check("R8 clear alone", d, 32'h0);
    int_req_i = '0;
    cycles(3);

    // R4 injection
    wr(6'h18, 32'hFFFF_FFFF);
    peek(6'h18, d); check("R4 injection readback, ext bits zero", d, 32'h000F_FFF0);
    @(negedge clk);
    peek(6'h00, d); check("R4 injection raises internal only", d, 32'h000F_FFF0);
    wr(6'h0C, ALL);
    peek(6'h00, d); check("R4 injection holds through clear", d, 32'h000F_FFF0);
    wr(6'h18, 32'h0);
    wr(6'h0C, ALL);
    cycles(2);
    peek(6'h00, d); check("R4 zero injection adds nothing", d, 32'h0);

    // random: R1 R3 R6 R7 R9
    for (int it = 0; it < 40; it++) begin
      e = $urandom & ALL;
      s = $urandom & ALL;
      p = $urandom & ALL;
      if (it == 0) begin e = ALL; s = 32'h0; p = ALL; end
      if (it == 1) begin e = ALL; s = ALL;   p = 32'h0008_0001; end
      wr(6'h04, e);
      wr(6'h08, s);
      wr(6'h0C, ALL);
      @(negedge clk);
      ext_req_i = p[3:0];
      int_req_i = p[19:4];
      cycles(4);
      peek(6'h00, d); check("R1 raw pending", d, p);
      peek(6'h14, d); check("R3 masked pending", d, p & e);
      peek(6'h20, d); check("R6 raw normal", d, f_rnrm(p, s));
      peek(6'h24, d); check("R6 raw fast", d, f_rfst(p, s));
      peek(6'h28, d); check("R7 masked normal", d, f_rnrm(p, s) & e);
      peek(6'h2C, d); check("R7 masked fast", d, f_rfst(p, s) & e);
      check("R9 irq_o level", {31'b0, irq_o}, {31'b0, |(f_rnrm(p, s) & e)});
      check("R9 fiq_o level", {31'b0, fiq_o}, {31'b0, |(f_rfst(p, s) & e)});
      ext_req_i = '0;
      int_req_i = '0;
      cycles(5);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule